// File: doc/BRIEF.md
# Chunked Image Staging Sequencer

This block is a host-side sequencer. It moves a firmware image from a local word-addressed memory into a mailbox device, using a simple 32-bit register bus. After a start pulse, it first resets the device with an abort write. It then runs a loop. Each pass sends one chunk of the image as a request object. The request is a mailbox header, a load command and the chunk's data words. The sequencer then writes the go bit and polls the device status until the device is ready. Next it reads a four-word response and checks it. The response tells the sequencer which image offset to send next. This offset may be one it has already sent, because the device can ask for the same piece again.

The loop ends in one of three ways: the device returns the all-ones end offset, a cap on the total bytes sent (twice the image length) would be exceeded, or a check fails. When the loop ends, the sequencer raises `done` and presents an error code. Both stay until the next start. The device's registers are selected by a two-bit word index on the bus:

| Index | Register |
|-------|----------|
| 0 | control |
| 1 | status |
| 2 | write data |
| 3 | read data |

Top module: `stg_sequencer`

## Requirements
- R1: A start with an image length that is not a multiple of 4 is refused. One cycle later `done`=1 and `err_code`=1 (alignment). No bus transaction is issued.
- R2: The first bus transaction after an accepted start writes 0x0000_0001 (abort) to register 0. The next transaction is the first request's header write, with no status read in between.
- R3: Each chunk is min(PAGE_BYTES, length − offset) bytes. An offset equal to the length gives an empty chunk: a request with no data words.
- R4: A request writes these words to register 2, in order: DEV_TAG; (16 + chunk bytes)/4; 0x3; 0x0; then the chunk's words read from memory word address offset/4 upward. It then writes 0x8000_0000 (go) to register 0. Every bus request stays stable until it is acknowledged.
- R5: After go, register 1 is read until bit 31 (ready) is seen, or POLL_LIMIT reads have been made. If the last status read has bit 2 set, `err_code`=3 (I/O), whether or not ready was seen. Otherwise, if ready never rose, `err_code`=4 (timeout).
- R6: The response is read from register 3 in the order header low, header high, offset, status. Each read is followed by a write of 0 to register 3.
- R7: A response header other than {low=DEV_TAG, high=4} gives `err_code`=5. This check takes priority over the offset and status checks.
- R8: A returned offset that is not 0xFFFF_FFFF and is greater than the image length gives `err_code`=6. This check takes priority over the status check.
- R9: A response status with bit 2 set gives `err_code`=7.
- R10: The next chunk starts at the offset the device returned, even if that chunk was sent before.
- R11: A returned offset of 0xFFFF_FFFF ends the run with `done`=1 and `err_code`=0.
- R12: Before each send, if bytes already sent plus the next chunk would exceed twice the length, the run ends with `err_code`=2. Nothing more is sent in that case.
- R13: After the run ends, `done` and `err_code` hold and the bus stays idle until the next start. `busy` and `done` are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| img_len | input | 32 | Image length in bytes |
| mem_rd_en | output | 1 | Image memory read strobe |
| mem_addr | output | AW | Image memory word address |
| mem_rdata | input | 32 | Image word, valid one cycle after the strobe |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 2 | Register word index |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction completes in a cycle with request and ack |
| bus_rdata | input | 32 | Read data, valid with ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| err_code | output | 3 | 0 ok, 1 align, 2 budget, 3 I/O, 4 timeout, 5 header, 6 offset, 7 protocol |

## Verification
The assertions make three assumptions about the environment:
- The bus responder only raises ack against a pending request.
- `start` is meaningful only while the block is idle.
- Image memory data is valid in the cycle after the read strobe.

The bench's device model respects all three. It acknowledges each request on the falling edge after that request appears, and drops ack for one cycle afterwards. It answers memory strobes on the same falling edge. It pulses `start` only after `done`, or out of reset. Responses are scripted per request, so every error path is reached with legal bus timing.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [2:0] {
    STG_OK        = 3'd0,
    STG_E_ALIGN   = 3'd1,
    STG_E_BUDGET  = 3'd2,
    STG_E_IO      = 3'd3,
    STG_E_TIMEOUT = 3'd4,
    STG_E_HDR     = 3'd5,
    STG_E_OFFSET  = 3'd6,
    STG_E_PROTO   = 3'd7
  } stg_err_e;

  localparam logic [1:0]  REG_CTRL   = 2'd0;
  localparam logic [1:0]  REG_STAT   = 2'd1;
  localparam logic [1:0]  REG_WDAT   = 2'd2;
  localparam logic [1:0]  REG_RDAT   = 2'd3;
  localparam logic [31:0] CTRL_ABORT = 32'h0000_0001;
  localparam logic [31:0] CTRL_GO    = 32'h8000_0000;
  localparam logic [31:0] CMD_LOAD   = 32'h0000_0003;
  localparam logic [31:0] END_OFFSET = 32'hFFFF_FFFF;
  localparam int          ST_READY   = 31;
  localparam int          ST_FAULT   = 2;
  localparam int          RSP_FAULT  = 2;
  localparam logic [31:0] TWO_HDR_BYTES = 32'd16;

  // bytes still to send from off, capped at one page
  function automatic logic [31:0] chunk_of(input logic [31:0] len,
                                           input logic [31:0] off,
                                           input logic [31:0] page);
    logic [31:0] rest;
    rest = len - off;
    return (rest < page) ? rest : page;
  endfunction

  // true when one more chunk would exceed twice the image length
  function automatic logic past_budget(input logic [33:0] sent,
                                       input logic [31:0] chunk,
                                       input logic [31:0] len);
    return (sent + {2'b00, chunk}) > {1'b0, len, 1'b0};
  endfunction

  // mailbox header size field, in dwords
  function automatic logic [31:0] req_size_words(input logic [31:0] chunk);
    return (TWO_HDR_BYTES + chunk) >> 2;
  endfunction

endpackage

// File: rtl/stg_chunk_calc.sv
module stg_chunk_calc
  import stg_pkg::*;
#(
  parameter int PAGE_BYTES = 4096
) (
  input  logic [31:0] len,
  input  logic [31:0] off,
  input  logic [33:0] sent,
  output logic [31:0] chunk,
  output logic        at_end,
  output logic        over
);
  localparam logic [31:0] PAGE = 32'(PAGE_BYTES);

  always_comb begin
    at_end = (off == END_OFFSET);
    chunk  = chunk_of(len, off, PAGE);
    over   = past_budget(sent, chunk, len);
  end
endmodule

// File: rtl/stg_resp_check.sv
module stg_resp_check
  import stg_pkg::*;
#(
  parameter logic [31:0] DEV_TAG = 32'h000B_8086
) (
  input  logic [31:0] hdr_lo,
  input  logic [31:0] hdr_hi,
  input  logic [31:0] nxt_off,
  input  logic [31:0] rsp_st,
  input  logic [31:0] len,
  output stg_err_e    verdict
);
  localparam logic [31:0] RSP_WORDS = 32'd4;

  logic hdr_bad, off_bad, st_bad;

  always_comb begin
    hdr_bad = (hdr_lo != DEV_TAG) || (hdr_hi != RSP_WORDS);
    off_bad = (nxt_off != END_OFFSET) && (nxt_off > len);
    st_bad  = rsp_st[RSP_FAULT];
    if (hdr_bad)      verdict = STG_E_HDR;
    else if (off_bad) verdict = STG_E_OFFSET;
    else if (st_bad)  verdict = STG_E_PROTO;
    else              verdict = STG_OK;
  end
endmodule

// File: rtl/stg_poll_timer.sv
module stg_poll_timer #(
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic last_try
);
  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt >= CW'(POLL_LIMIT - 1));
endmodule

// File: rtl/stg_sequencer.sv
module stg_sequencer
  import stg_pkg::*;
#(
  parameter int          PAGE_BYTES = 4096,
  parameter int          POLL_LIMIT = 1000,
  parameter int          AW         = 12,
  parameter logic [31:0] DEV_TAG    = 32'h000B_8086
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   img_len,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [1:0]    bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [31:0]   bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err_code
);
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int WCW        = $clog2(PAGE_WORDS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ABORT, S_PLAN, S_HDR_LO, S_HDR_HI, S_CMD_LO, S_CMD_HI,
    S_FETCH, S_LATCH, S_DATA, S_GO, S_POLL, S_RD, S_RACK, S_EVAL
  } state_e;

  state_e      state;
  stg_err_e    err_q;
  logic [31:0] len_q, off_q, chunk_q, wbuf;
  logic [33:0] sent_q;
  logic [WCW-1:0] wcnt;
  logic [1:0]  ridx;
  logic [31:0] rsp [4];

  logic [31:0] plan_chunk;
  logic        plan_end, plan_over, poll_last;
  stg_err_e    rsp_verdict;

  // named internal events for the checker
  logic ev_abort_wr, ev_go_wr, ev_finish, ack_now, last_word, st_ready;
  assign ack_now     = bus_req && bus_ack;
  assign ev_abort_wr = (state == S_ABORT) && bus_ack;
  assign ev_go_wr    = (state == S_GO) && bus_ack;
  assign last_word   = ((32'(wcnt) + 32'd1) == (chunk_q >> 2));
  assign st_ready    = bus_rdata[ST_READY];

  stg_chunk_calc #(.PAGE_BYTES(PAGE_BYTES)) u_calc (
    .len(len_q), .off(off_q), .sent(sent_q),
    .chunk(plan_chunk), .at_end(plan_end), .over(plan_over)
  );

  stg_resp_check #(.DEV_TAG(DEV_TAG)) u_rchk (
    .hdr_lo(rsp[0]), .hdr_hi(rsp[1]), .nxt_off(rsp[2]), .rsp_st(rsp[3]),
    .len(len_q), .verdict(rsp_verdict)
  );

  stg_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(ev_go_wr),
    .tick((state == S_POLL) && bus_ack), .last_try(poll_last)
  );

  // bus request decode: a pure function of the registered state
  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = REG_WDAT;
    bus_wdata = 32'd0;
    case (state)
      S_ABORT:  begin bus_addr = REG_CTRL; bus_wdata = CTRL_ABORT; end
      S_HDR_LO: bus_wdata = DEV_TAG;
      S_HDR_HI: bus_wdata = req_size_words(chunk_q);
      S_CMD_LO: bus_wdata = CMD_LOAD;
      S_CMD_HI: bus_wdata = 32'd0;
      S_DATA:   bus_wdata = wbuf;
      S_GO:     begin bus_addr = REG_CTRL; bus_wdata = CTRL_GO; end
      S_POLL:   begin bus_we = 1'b0; bus_addr = REG_STAT; end
      S_RD:     begin bus_we = 1'b0; bus_addr = REG_RDAT; end
      S_RACK:   bus_addr = REG_RDAT;
      default:  bus_req = 1'b0;
    endcase
  end

  assign mem_rd_en = (state == S_FETCH);
  assign mem_addr  = AW'(off_q >> 2) + AW'(wcnt);
  assign busy      = (state != S_IDLE);
  assign err_code  = err_q;
  assign ev_finish = busy && !(state inside {S_ABORT, S_HDR_LO, S_HDR_HI, S_CMD_LO,
                     S_CMD_HI, S_FETCH, S_LATCH, S_DATA, S_RD, S_RACK})
                     && ((state == S_PLAN && (plan_end || plan_over))
                      || (state == S_POLL && bus_ack && (st_ready || poll_last)
                          && (bus_rdata[ST_FAULT] || !st_ready))
                      || (state == S_EVAL && rsp_verdict != STG_OK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      err_q   <= STG_OK;
      len_q   <= '0;
      off_q   <= '0;
      sent_q  <= '0;
      chunk_q <= '0;
      wbuf    <= '0;
      wcnt    <= '0;
      ridx    <= '0;
      for (int i = 0; i < 4; i++) rsp[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (img_len[1:0] != 2'b00) begin
            done  <= 1'b1;
            err_q <= STG_E_ALIGN;
          end else begin
            done   <= 1'b0;
            err_q  <= STG_OK;
            len_q  <= img_len;
            off_q  <= '0;
            sent_q <= '0;
            state  <= S_ABORT;
          end
        end
        S_ABORT: if (ack_now) state <= S_PLAN;
        S_PLAN: begin
          if (plan_end) begin
            done <= 1'b1; state <= S_IDLE;
          end else if (plan_over) begin
            done <= 1'b1; err_q <= STG_E_BUDGET; state <= S_IDLE;
          end else begin
            chunk_q <= plan_chunk;
            state   <= S_HDR_LO;
          end
        end
        S_HDR_LO: if (ack_now) state <= S_HDR_HI;
        S_HDR_HI: if (ack_now) state <= S_CMD_LO;
        S_CMD_LO: if (ack_now) state <= S_CMD_HI;
        S_CMD_HI: if (ack_now) begin
          wcnt  <= '0;
          state <= (chunk_q == 32'd0) ? S_GO : S_FETCH;
        end
        S_FETCH: state <= S_LATCH;
        S_LATCH: begin wbuf <= mem_rdata; state <= S_DATA; end
        S_DATA: if (ack_now) begin
          wcnt  <= wcnt + 1'b1;
          state <= last_word ? S_GO : S_FETCH;
        end
        S_GO: if (ack_now) begin
          sent_q <= sent_q + {2'b00, chunk_q};
          state  <= S_POLL;
        end
        S_POLL: if (ack_now && (st_ready || poll_last)) begin
          if (bus_rdata[ST_FAULT]) begin
            done <= 1'b1; err_q <= STG_E_IO; state <= S_IDLE;
          end else if (!st_ready) begin
            done <= 1'b1; err_q <= STG_E_TIMEOUT; state <= S_IDLE;
          end else begin
            ridx <= '0; state <= S_RD;
          end
        end
        S_RD: if (ack_now) begin
          rsp[ridx] <= bus_rdata;
          state     <= S_RACK;
        end
        S_RACK: if (ack_now) begin
          ridx  <= ridx + 1'b1;
          state <= (ridx == 2'd3) ? S_EVAL : S_RD;
        end
        S_EVAL: begin
          if (rsp_verdict != STG_OK) begin
            done <= 1'b1; err_q <= rsp_verdict; state <= S_IDLE;
          end else begin
            off_q <= rsp[2];
            state <= S_PLAN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stg_sequencer_chk.sv
module stg_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] img_len,
  input logic        busy,
  input logic        done,
  input logic [2:0]  err_code,
  input logic        bus_req,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack,
  input logic [33:0] sent_bytes,
  input logic [31:0] len_q,
  input logic        ev_finish,
  input logic        ev_go_wr
);
  // R1
  align_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && img_len[1:0] != 2'b00) |=> (done && err_code == 3'd1 && !busy));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_wdata)));

  // R12
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sent_bytes <= {1'b0, len_q, 1'b0}));

  // R13
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R13
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(err_code) && !busy));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  // R13
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (done && !busy));

  // R5
  go_then_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go_wr |=> (bus_req && !bus_we && bus_addr == 2'd1));
endmodule

bind stg_sequencer stg_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
  .busy(busy), .done(done), .err_code(err_code),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .sent_bytes(sent_q), .len_q(len_q),
  .ev_finish(ev_finish), .ev_go_wr(ev_go_wr)
);

// File: tb/tb_stg_sequencer.sv
module tb_stg_sequencer;
  localparam int PAGE = 16;
  localparam int PLIM = 8;
  localparam int AW   = 12;
  localparam logic [31:0] TAG  = 32'h000B_8086;
  localparam logic [31:0] GOV  = 32'h8000_0000;
  localparam logic [31:0] ENDV = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] img_len = '0;
  logic mem_rd_en; logic [AW-1:0] mem_addr; logic [31:0] mem_rdata = '0;
  logic bus_req, bus_we; logic [1:0] bus_addr; logic [31:0] bus_wdata;
  logic bus_ack = 1'b0; logic [31:0] bus_rdata = '0;
  logic busy, done; logic [2:0] err_code;

  always #4 clk = ~clk;

  stg_sequencer #(.PAGE_BYTES(PAGE), .POLL_LIMIT(PLIM), .AW(AW), .DEV_TAG(TAG)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .err_code(err_code)
  );

  int n_chk = 0, n_fail = 0;

  // scripted device responses, one set per go
  logic [31:0] c_lo [16], c_hi [16], c_off [16], c_st [16], c_fin [16];
  int          c_pre [16];
  int ngo = 0, spoll = 0, rix = 0;

  // transaction log and expected list
  logic        l_we [512], e_we [512], e_cmp [512];
  logic [1:0]  l_ad [512], e_ad [512];
  logic [31:0] l_dt [512], e_dt [512];
  int n_log = 0, n_exp = 0;

  function automatic logic [31:0] img_word(input int a);
    return 32'hA500_0000 + 32'(a);
  endfunction

  // device and memory model
  initial forever begin
    @(negedge clk);
    if (mem_rd_en) mem_rdata = img_word(int'(mem_addr));
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (n_log < 512) begin
        l_we[n_log] = bus_we; l_ad[n_log] = bus_addr; l_dt[n_log] = bus_wdata;
        n_log++;
      end
      if (bus_we && bus_addr == 2'd0 && bus_wdata == GOV) begin
        ngo++; spoll = 0; rix = 0;
      end
      if (!bus_we && bus_addr == 2'd1) begin
        bus_rdata = (spoll < c_pre[ngo-1]) ? 32'd0 : c_fin[ngo-1];
        spoll++;
      end
      if (!bus_we && bus_addr == 2'd3) begin
        case (rix)
          0: bus_rdata = c_lo[ngo-1];
          1: bus_rdata = c_hi[ngo-1];
          2: bus_rdata = c_off[ngo-1];
          default: bus_rdata = c_st[ngo-1];
        endcase
        rix++;
      end
      bus_ack = 1'b1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg(input int t, input logic [31:0] hi, input logic [31:0] off,
                     input logic [31:0] st, input int pre, input logic [31:0] fin);
    c_lo[t] = TAG; c_hi[t] = hi; c_off[t] = off; c_st[t] = st;
    c_pre[t] = pre; c_fin[t] = fin;
  endtask

  task automatic ex(input logic we, input logic [1:0] ad, input logic [31:0] dt);
    e_we[n_exp] = we; e_ad[n_exp] = ad; e_dt[n_exp] = dt; e_cmp[n_exp] = we;
    n_exp++;
  endtask

  task automatic ex_req(input int off, input int chunk);
    ex(1, 2, TAG); ex(1, 2, 32'((16 + chunk) / 4)); ex(1, 2, 32'd3); ex(1, 2, 32'd0);
    for (int i = 0; i < chunk / 4; i++) ex(1, 2, img_word(off / 4 + i));
    ex(1, 0, GOV);
  endtask

  task automatic ex_polls(input int n);
    for (int i = 0; i < n; i++) ex(0, 1, 32'd0);
  endtask

  task automatic ex_rsp();
    for (int i = 0; i < 4; i++) begin ex(0, 3, 32'd0); ex(1, 3, 32'd0); end
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    chk(n_log == n_exp, {req, " transaction count"}, 32'(n_log), 32'(n_exp));
    for (int i = 0; i < n_exp && i < n_log; i++)
      if (bad < 0 && (l_we[i] != e_we[i] || l_ad[i] != e_ad[i] ||
                      (e_cmp[i] && l_dt[i] != e_dt[i]))) bad = i;
    if (bad >= 0)
      chk(1'b0, {req, " transaction sequence"}, l_dt[bad], e_dt[bad]);
    else
      chk(1'b1, req, 0, 0);
  endtask

  task automatic run(input logic [31:0] len);
    n_log = 0; n_exp = 0; ngo = 0;
    @(negedge clk); img_len = len; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !bus_req, "R13 reset idle", {29'd0, busy, done, bus_req}, 0);
    chk(err_code == 3'd0, "R13 reset code", 32'(err_code), 0);
  endtask

  task automatic t_align();
    run(32'd10);
    chk(done && err_code == 3'd1, "R1 misaligned refused", 32'(err_code), 1);
    chk(n_log == 0, "R1 no bus traffic", 32'(n_log), 0);
  endtask

  task automatic t_normal();
    cfg(0, 4, 16, 1, 1, GOV); cfg(1, 4, ENDV, 1, 0, GOV);
    run(32'd24);
    ex(1, 0, 32'd1);
    ex_req(0, 16); ex_polls(2); ex_rsp();
    ex_req(16, 8); ex_polls(1); ex_rsp();
    chk(done && err_code == 3'd0, "R11 end sentinel success", 32'(err_code), 0);
    chk(l_we[0] && l_ad[0] == 2'd0 && l_dt[0] == 32'd1, "R2 abort first", l_dt[0], 1);
    cmp_log("R4 R3 R6 request and response order");
  endtask

  task automatic t_repeat();
    cfg(0, 4, 0, 1, 0, GOV); cfg(1, 4, 16, 1, 0, GOV); cfg(2, 4, ENDV, 1, 0, GOV);
    run(32'd24);
    ex(1, 0, 32'd1);
    ex_req(0, 16); ex_polls(1); ex_rsp();
    ex_req(0, 16); ex_polls(1); ex_rsp();
    ex_req(16, 8); ex_polls(1); ex_rsp();
    chk(err_code == 3'd0, "R10 repeat offset completes", 32'(err_code), 0);
    cmp_log("R10 resend follows device offset");
  endtask

  task automatic t_budget();
    cfg(0, 4, 0, 1, 0, GOV); cfg(1, 4, 0, 1, 0, GOV); cfg(2, 4, 0, 1, 0, GOV);
    run(32'd16);
    ex(1, 0, 32'd1);
    ex_req(0, 16); ex_polls(1); ex_rsp();
    ex_req(0, 16); ex_polls(1); ex_rsp();
    chk(err_code == 3'd2, "R12 budget error", 32'(err_code), 2);
    cmp_log("R12 no send past budget");
  endtask

  task automatic t_empty_chunk();
    cfg(0, 4, 16, 1, 0, GOV); cfg(1, 4, ENDV, 1, 0, GOV);
    run(32'd16);
    ex(1, 0, 32'd1);
    ex_req(0, 16); ex_polls(1); ex_rsp();
    ex_req(16, 0); ex_polls(1); ex_rsp();
    chk(err_code == 3'd0, "R3 offset equal to length accepted", 32'(err_code), 0);
    cmp_log("R3 empty chunk request");
  endtask

  task automatic t_timeout();
    cfg(0, 4, ENDV, 1, 100, GOV);
    run(32'd8);
    ex(1, 0, 32'd1); ex_req(0, 8); ex_polls(PLIM);
    chk(err_code == 3'd4, "R5 timeout", 32'(err_code), 4);
    cmp_log("R5 poll limit reads");
  endtask

  task automatic t_io();
    cfg(0, 4, ENDV, 1, 2, GOV | 32'h4);
    run(32'd8);
    chk(err_code == 3'd3, "R5 I/O error with ready", 32'(err_code), 3);
    cfg(0, 4, ENDV, 1, 100, 32'h4);
    c_pre[0] = 0;
    run(32'd8);
    chk(err_code == 3'd3, "R5 I/O error without ready", 32'(err_code), 3);
  endtask

  task automatic t_hdr();
    cfg(0, 5, 32'd100, 4, 0, GOV);
    run(32'd8);
    chk(err_code == 3'd5, "R7 bad header priority", 32'(err_code), 5);
    cfg(0, 4, ENDV, 0, 0, GOV); c_lo[0] = TAG ^ 32'h1;
    run(32'd8);
    chk(err_code == 3'd5, "R7 bad header tag", 32'(err_code), 5);
  endtask

  task automatic t_offset();
    cfg(0, 4, 32'd12, 4, 0, GOV);
    run(32'd8);
    chk(err_code == 3'd6, "R8 offset past end", 32'(err_code), 6);
  endtask

  task automatic t_proto();
    cfg(0, 4, 32'd8, 4, 0, GOV);
    run(32'd8);
    chk(err_code == 3'd7, "R9 protocol status", 32'(err_code), 7);
  endtask

  task automatic t_hold();
    int n0 = n_log;
    repeat (6) @(negedge clk);
    chk(done && !busy && err_code == 3'd7, "R13 result held", 32'(err_code), 7);
    chk(n_log == n0 && !bus_req, "R13 bus idle after done", 32'(n_log), 32'(n0));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) cfg(i, 4, ENDV, 1, 0, GOV);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_align();
    t_normal();
    t_repeat();
    t_budget();
    t_empty_chunk();
    t_timeout();
    t_io();
    t_hdr();
    t_offset();
    t_proto();
    t_hold();
    finish_run();
  end
endmodule